// File: doc/BRIEF.md
# Eight-Bit Timer with Compare-Clear and Single-Slope PWM Waveforms

This block is an up-counting timer with two compare channels and a waveform generator for each. It advances on a count-enable tick, which comes from an external prescaler that divides the clock by 1, 8, 32, 64, 128, 256 or 1024. A three-bit mode input picks how the counter runs. In compare-clear mode (code 2) the counter restarts after it matches compare register A. In single-slope fast PWM mode the counter runs from zero up to a top value and then restarts. Code 3 uses all-ones as the top, and code 7 uses compare register A as the top. Any other code lets the counter run freely and wrap at all-ones.

Each channel has its own two-bit output-mode field. In modes other than fast PWM, the field toggles, clears or sets the channel's pin on a compare match. In fast PWM it gives a non-inverting or inverting pulse. In compare-clear mode a write to a compare register takes effect at once, with no buffer. In fast PWM a write is held in a shadow register and moves to the active register when the counter returns to zero. Three sticky flags report match A, match B and counter overflow. They are cleared by a write-one pulse.

Top module: `tmr8_wavegen`

## Requirements
- R1: During and right after reset, the count is 0, both waveform pins are 0 and all three flags are 0.
- R2: The count and both waveform pins change only on clock edges where `tick` is high. Compare writes and flag clears are accepted whatever `tick` is.
- R3: In mode 2, the counter goes to 0 on the tick after the count equals compare A. With output mode 01 the pin toggles on every such match, so with compare A = N and `tick` held high the pin changes every N+1 clocks. With compare A = 0 the pin period is 2 clocks.
- R4: In mode 2, a compare write applies on the next clock. If the new value is below the current count, no match occurs until the counter has run to 255 and wrapped to 0. It then matches at the new value.
- R5: In modes other than 3 and 7, output mode 11 sets the pin on a match and output mode 10 clears it.
- R6: In mode 3, the counter wraps from 255 to 0. With output mode 10 the pin is 1 exactly while count <= compare value. With output mode 11 the pin is 1 exactly while count > compare value. With a compare value of 255 in mode 10, the pin stays at 1.
- R7: In mode 7, the counter wraps after reaching compare A, so the overflow flag stays clear when compare A < 255. Channel A with output mode 01 toggles on each match, once every compare A + 1 ticks. Channel B ignores output mode 01 and holds its pin.
- R8: In modes 3 and 7, a compare write is held back until the next wrap to 0. The period that is running when the write arrives ends at the old top.
- R9: Output mode 00 freezes a channel's pin at its last value in every mode.
- R10: Flag bit 0 (match A) is set on a tick where count equals active compare A. Bit 1 (match B) is set in the same way for compare B. Bit 2 (overflow) is set on the tick where the count goes from 255 to 0.
- R11: Flags hold until a 1 arrives on the same bit of `flag_clr`. If a set event and a clear occur in the same cycle, the set wins. Clearing one bit leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wave_mode | input | 3 | Counter mode: 2 compare-clear, 3 PWM with all-ones top, 7 PWM with compare A as top |
| out_mode_a | input | 2 | Channel A output mode: 00 hold, 01 toggle, 10 clear/non-inverting, 11 set/inverting |
| out_mode_b | input | 2 | Channel B output mode, same encoding as channel A |
| cmp_a_we | input | 1 | Write strobe for compare A |
| cmp_a_din | input | W | Value written to compare A |
| cmp_b_we | input | 1 | Write strobe for compare B |
| cmp_b_din | input | W | Value written to compare B |
| flag_clr | input | 3 | Write-one-to-clear pulses for the flags {overflow, match B, match A} |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| match_a_flag | output | 1 | Sticky match A flag |
| match_b_flag | output | 1 | Sticky match B flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| count | output | W | Current counter value |

## Verification
Two situations are hard to reach from the ports: a compare write that lands below a running count in compare-clear mode, and a write that lands in the middle of a PWM period. Both need the write to arrive at a known count. The bench runs the counter with the tick held high and polls `count` each cycle. When the count reaches 50, it writes a lower compare value. It then confirms that no match happens before the count hits 255 and wraps to 0. In mode 7 it writes a new top when the count reaches 40. It then records the highest count in that period and in the next one, which shows when the shadow value took effect.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   localparam logic [2:0] WM_CTC     = 3'd2;
   localparam logic [2:0] WM_PWM_MAX = 3'd3;
   localparam logic [2:0] WM_PWM_A   = 3'd7;

   typedef enum logic [1:0] {
      OM_HOLD   = 2'b00,
      OM_TOGGLE = 2'b01,
      OM_CLEAR  = 2'b10,
      OM_SET    = 2'b11
   } out_mode_e;

   localparam int unsigned N_CH   = 2;
   localparam int unsigned N_FLAG = 3;

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] top_val,
   output logic [W-1:0] cnt,
   output logic         bottom_ev,
   output logic         max_ev
);
   localparam logic [W-1:0] CNT_MAX = '1;

   // wrap either at the programmed top or, if the top was passed, at all-ones
   always_comb begin
      max_ev    = tick && (cnt == CNT_MAX);
      bottom_ev = tick && ((cnt == top_val) || (cnt == CNT_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (bottom_ev) cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tmr8_cmp_reg.sv
module tmr8_cmp_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         buffered,
   input  logic         load,
   input  logic         we,
   input  logic [W-1:0] din,
   output logic [W-1:0] act
);
   logic [W-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         act    <= '0;
      end else begin
         if (we) shadow <= din;
         if (!buffered) begin
            if (we) act <= din;
         end else if (load) begin
            act <= we ? din : shadow;
         end
      end
   end
endmodule

// File: rtl/tmr8_wave_ch.sv
module tmr8_wave_ch
   import tmr8_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm,
   input  logic       pwm_tgl_en,
   input  logic [1:0] om_bits,
   input  logic       match,
   input  logic       bottom,
   output logic       wave
);
   out_mode_e om;
   logic      nxt;

   always_comb begin
      om  = out_mode_e'(om_bits);
      nxt = wave;
      if (!pwm) begin
         if (match) begin
            case (om)
               OM_TOGGLE: nxt = ~wave;
               OM_CLEAR:  nxt = 1'b0;
               OM_SET:    nxt = 1'b1;
               default:   nxt = wave;
            endcase
         end
      end else begin
         case (om)
            OM_TOGGLE: if (match && pwm_tgl_en) nxt = ~wave;
            OM_CLEAR: begin
               if (bottom)     nxt = 1'b1;
               else if (match) nxt = 1'b0;
            end
            OM_SET: begin
               if (bottom)     nxt = 1'b0;
               else if (match) nxt = 1'b1;
            end
            default: nxt = wave;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave <= 1'b0;
      else        wave <= nxt;
   end
endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
   import tmr8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [2:0]   wave_mode,
   input  logic [1:0]   out_mode_a,
   input  logic [1:0]   out_mode_b,
   input  logic         cmp_a_we,
   input  logic [W-1:0] cmp_a_din,
   input  logic         cmp_b_we,
   input  logic [W-1:0] cmp_b_din,
   input  logic [2:0]   flag_clr,
   output logic         wave_a,
   output logic         wave_b,
   output logic         match_a_flag,
   output logic         match_b_flag,
   output logic         ovf_flag,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] CNT_MAX = '1;

   if (W < 2) begin : g_bad_width
      $error("tmr8_wavegen: W must be at least 2");
   end

   logic         is_ctc, is_pwm, top_from_a;
   logic [W-1:0] top_val, act_a, act_b;
   logic         bottom_ev, max_ev;

   logic [W-1:0]      cmp_din [N_CH];
   logic [N_CH-1:0]   cmp_we;
   logic [W-1:0]      cmp_act [N_CH];
   logic [N_CH-1:0]   match_ev, pwm_tgl, wave_q;
   logic [1:0]        om_sel  [N_CH];
   logic [N_FLAG-1:0] flag_set, flag_q;

   always_comb begin
      is_ctc     = (wave_mode == WM_CTC);
      is_pwm     = (wave_mode == WM_PWM_MAX) || (wave_mode == WM_PWM_A);
      top_from_a = is_ctc || (wave_mode == WM_PWM_A);
      top_val    = top_from_a ? act_a : CNT_MAX;
      cmp_din[0] = cmp_a_din;
      cmp_din[1] = cmp_b_din;
      cmp_we     = {cmp_b_we, cmp_a_we};
      om_sel[0]  = out_mode_a;
      om_sel[1]  = out_mode_b;
   end

   tmr8_count #(.W(W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .top_val   (top_val),
      .cnt       (count),
      .bottom_ev (bottom_ev),
      .max_ev    (max_ev)
   );

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      tmr8_cmp_reg #(.W(W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .buffered (is_pwm),
         .load     (bottom_ev),
         .we       (cmp_we[ch]),
         .din      (cmp_din[ch]),
         .act      (cmp_act[ch])
      );

      assign match_ev[ch] = tick && (count == cmp_act[ch]);
      // only channel A may toggle in PWM, and only when it also sets the top
      assign pwm_tgl[ch]  = (ch == 0) ? (wave_mode == WM_PWM_A) : 1'b0;

      tmr8_wave_ch u_wave (
         .clk        (clk),
         .rst_n      (rst_n),
         .pwm        (is_pwm),
         .pwm_tgl_en (pwm_tgl[ch]),
         .om_bits    (om_sel[ch]),
         .match      (match_ev[ch]),
         .bottom     (bottom_ev),
         .wave       (wave_q[ch])
      );
   end

   assign act_a    = cmp_act[0];
   assign act_b    = cmp_act[1];
   assign flag_set = {max_ev, match_ev[1], match_ev[0]};

   for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           flag_q[f] <= 1'b0;
         else if (flag_set[f]) flag_q[f] <= 1'b1;
         else if (flag_clr[f]) flag_q[f] <= 1'b0;
      end
   end

   assign wave_a       = wave_q[0];
   assign wave_b       = wave_q[1];
   assign match_a_flag = flag_q[0];
   assign match_b_flag = flag_q[1];
   assign ovf_flag     = flag_q[2];
endmodule

// File: rtl/tmr8_wavegen_chk.sv
module tmr8_wavegen_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic [2:0]   wave_mode,
   input logic [1:0]   out_mode_a,
   input logic [1:0]   out_mode_b,
   input logic [2:0]   flag_clr,
   input logic [W-1:0] count,
   input logic         wave_a,
   input logic         wave_b,
   input logic         match_a_flag,
   input logic         ovf_flag,
   input logic [W-1:0] act_a
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic pwm_mode;
   assign pwm_mode = (wave_mode == 3'd3) || (wave_mode == 3'd7);

   a_r2_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   a_r2_idle_wave: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(wave_a) && $stable(wave_b)));

   a_r3_ctc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode == 3'd2 && tick && count == act_a) |=> (count == '0));

   a_r3_ctc_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode == 3'd2 && out_mode_a == 2'b01 && tick && count == act_a)
      |=> (wave_a != $past(wave_a)));

   a_r7_top_from_a: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode == 3'd7 && tick && count == act_a) |=> (count == '0));

   a_r7_b_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && out_mode_b == 2'b01) |=> $stable(wave_b));

   a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode_a == 2'b00) |=> $stable(wave_a));

   a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == CNT_MAX) |=> (ovf_flag && count == '0));

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr[2]) |=> ovf_flag);

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == act_a) |=> match_a_flag);
endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.W(W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .wave_mode    (wave_mode),
   .out_mode_a   (out_mode_a),
   .out_mode_b   (out_mode_b),
   .flag_clr     (flag_clr),
   .count        (count),
   .wave_a       (wave_a),
   .wave_b       (wave_b),
   .match_a_flag (match_a_flag),
   .ovf_flag     (ovf_flag),
   .act_a        (act_a)
);

// File: tb/tmr8_wavegen_tb.sv
module tmr8_wavegen_tb;
   localparam int CLK_PER = 10;
   localparam int N_VEC   = 4;
   // {compare A, expected clocks between toggles}
   localparam int CTC_VEC [N_VEC][2] = '{'{0, 1}, '{3, 4}, '{17, 18}, '{200, 201}};

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic [2:0] wmode = 3'd0, fclr = 3'd0;
   logic [1:0] oma = 2'd0, omb = 2'd0;
   logic       cawe = 1'b0, cbwe = 1'b0;
   logic [7:0] cad = 8'd0, cbd = 8'd0;
   logic       wave_a, wave_b, mfa, mfb, ovf;
   logic [7:0] count;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;

   tmr8_wavegen #(.W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wmode),
      .out_mode_a(oma), .out_mode_b(omb),
      .cmp_a_we(cawe), .cmp_a_din(cad), .cmp_b_we(cbwe), .cmp_b_din(cbd),
      .flag_clr(fclr), .wave_a(wave_a), .wave_b(wave_b),
      .match_a_flag(mfa), .match_b_flag(mfb), .ovf_flag(ovf), .count(count)
   );

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #(CLK_PER/4);
      end
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b0; fclr = 3'd0; cawe = 1'b0; cbwe = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic wr_a(input logic [7:0] v);
      cad = v; cawe = 1'b1; step(1); cawe = 1'b0;
   endtask

   task automatic wr_b(input logic [7:0] v);
      cbd = v; cbwe = 1'b1; step(1); cbwe = 1'b0;
   endtask

   task automatic toggle_gap(output int gap);
      logic ref_v;
      ref_v = wave_a;
      for (int i = 0; i < 1000 && wave_a == ref_v; i++) step(1);
      ref_v = wave_a;
      gap = 0;
      for (int i = 0; i < 1000 && wave_a == ref_v; i++) begin
         step(1);
         gap++;
      end
   endtask

   task automatic until_count(input logic [7:0] v);
      for (int i = 0; i < 600 && count != v; i++) step(1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PER * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int g, mx, mis_a, mis_b;
      logic [7:0] c0;
      logic w0;

      // R1 reset state
      step(2);
      chk(count == 0, "R1 count in reset", count, 0);
      rst_n = 1'b1;
      step(1);
      chk(count == 0, "R1 count", count, 0);
      chk(wave_a == 0 && wave_b == 0, "R1 waves", {wave_a, wave_b}, 0);
      chk({ovf, mfb, mfa} == 3'b000, "R1 flags", {ovf, mfb, mfa}, 0);

      // R3 compare-clear toggle periods from the vector table
      for (int k = 0; k < N_VEC; k++) begin
         do_reset();
         wmode = 3'd2; oma = 2'b01;
         wr_a(8'(CTC_VEC[k][0]));
         tick = 1'b1;
         toggle_gap(g);
         chk(g == CTC_VEC[k][1], "R3 toggle period", g, CTC_VEC[k][1]);
      end

      // R4 late low write in compare-clear mode
      do_reset();
      wmode = 3'd2; oma = 2'b00;
      wr_a(8'd100);
      tick = 1'b1;
      until_count(8'd50);
      cad = 8'd20; cawe = 1'b1; fclr = 3'b111;
      step(1);
      cawe = 1'b0; fclr = 3'b000;
      until_count(8'd255);
      chk(mfa == 1'b0, "R4 no match before wrap", mfa, 0);
      chk(ovf == 1'b0, "R4 overflow not yet", ovf, 0);
      step(1);
      chk(count == 0, "R4 wrap to zero", count, 0);
      chk(ovf == 1'b1, "R10 overflow on wrap", ovf, 1);
      until_count(8'd20);
      step(1);
      chk(count == 0, "R4 clear at new compare", count, 0);
      chk(mfa == 1'b1, "R10 match A flag", mfa, 1);

      // R2 tick gating
      tick = 1'b0;
      c0 = count; w0 = wave_b;
      step(20);
      chk(count == c0, "R2 count frozen", count, c0);
      chk(wave_b == w0, "R2 wave frozen", wave_b, w0);
      tick = 1'b1;
      step(1);
      chk(count == c0 + 8'd1, "R2 count resumes", count, c0 + 8'd1);

      // R5 set and clear on match outside PWM
      omb = 2'b11;
      wr_b(8'd3);
      until_count(8'd5);
      chk(wave_b == 1'b1, "R5 set on match", wave_b, 1);
      omb = 2'b10;
      step(1);
      until_count(8'd5);
      chk(wave_b == 1'b0, "R5 clear on match", wave_b, 0);
      chk(mfb == 1'b1, "R10 match B flag", mfb, 1);

      // R11 set beats clear, clear alone works, other bits kept
      wr_a(8'd0);
      until_count(8'd0);
      fclr = 3'b001;
      step(1);
      chk(mfa == 1'b1, "R11 set wins over clear", mfa, 1);
      tick = 1'b0;
      step(1);
      fclr = 3'b000;
      chk(mfa == 1'b0, "R11 clear pulse", mfa, 0);
      chk(ovf == 1'b1, "R11 other flag kept", ovf, 1);

      // R6 mode 3 non-inverting on B, inverting on A
      do_reset();
      wmode = 3'd3; oma = 2'b11; omb = 2'b10;
      wr_a(8'd200);
      wr_b(8'd64);
      tick = 1'b1;
      until_count(8'd255);
      step(1);
      mis_a = 0; mis_b = 0;
      for (int i = 0; i < 256; i++) begin
         if (wave_a != (count > 8'd200)) mis_a++;
         if (wave_b != (count <= 8'd64)) mis_b++;
         step(1);
      end
      chk(mis_a == 0, "R6 inverting duty", mis_a, 0);
      chk(mis_b == 0, "R6 non-inverting duty", mis_b, 0);
      chk(ovf == 1'b1, "R10 overflow in mode 3", ovf, 1);
      wr_b(8'd255);
      until_count(8'd255);
      step(1);
      mis_b = 0;
      for (int i = 0; i < 256; i++) begin
         if (wave_b != 1'b1) mis_b++;
         step(1);
      end
      chk(mis_b == 0, "R6 compare at top stays high", mis_b, 0);

      // R7 mode 7, top from compare A
      do_reset();
      wmode = 3'd7; oma = 2'b01; omb = 2'b01;
      wr_b(8'd30);
      tick = 1'b1;
      wr_a(8'd99);
      fclr = 3'b111;
      step(1);
      fclr = 3'b000;
      w0 = wave_b; mx = 0;
      for (int i = 0; i < 300; i++) begin
         if (int'(count) > mx) mx = int'(count);
         step(1);
      end
      chk(mx == 99, "R7 top equals compare A", mx, 99);
      chk(ovf == 1'b0, "R7 no overflow", ovf, 0);
      chk(wave_b == w0, "R7 channel B toggle ignored", wave_b, w0);
      chk(mfb == 1'b1, "R10 match B in mode 7", mfb, 1);
      toggle_gap(g);
      chk(g == 100, "R7 channel A toggle period", g, 100);

      // R8 double buffering in mode 7
      until_count(8'd40);
      wr_a(8'd49);
      mx = 0;
      for (int i = 0; i < 300; i++) begin
         step(1);
         if (int'(count) > mx) mx = int'(count);
         if (count == 0) break;
      end
      chk(mx == 99, "R8 old top kept this period", mx, 99);
      mx = 0;
      for (int i = 0; i < 300; i++) begin
         step(1);
         if (int'(count) > mx) mx = int'(count);
         if (count == 0) break;
      end
      chk(mx == 49, "R8 new top next period", mx, 49);

      // R9 output mode 00 holds
      oma = 2'b00;
      w0 = wave_a;
      step(150);
      chk(wave_a == w0, "R9 disconnected output holds", wave_a, w0);

      summary();
      $finish;
   end
endmodule